// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

The bridge gives a host CPU access to a paged internal switch register space through a window of 32-bit bus registers. Before it issues any command, the host must own the bridge. It sets a request bit, and the bridge answers with a grant bit one cycle later. The host then stages up to 64 bits of write data in a high word and a low word. It writes a command that holds a page number, a register offset, a direction flag and a go bit. The go bit reads back as 1 while the internal access runs. The bridge clears it when the access finishes, and for a read the returned 64 bits then appear in two read-data words.

The internal access goes to a modelled switch register file through a single-cycle synchronous port. It completes a fixed number of cycles after the command is accepted. Narrow accesses (8, 16 and 32 bits) use only the low data words. A 48-bit access keeps its upper 16 bits in the low half of the high word. The bridge also latches interrupt pulses from the switch into a sticky register that the host clears by writing ones. It drives a host interrupt line when the host has enabled it.

Top module: `pgb_bridge`

## Requirements
- R1: After reset, every mapped register reads 0 apart from the init-done bit. Offsets: command 0x2C, write-data high 0x30, write-data low 0x34, read-data high 0x38, read-data low 0x3C, control 0x40, interrupt 0x44. A read of any other offset returns 0. Read data appears on `bus_rdata_o` one cycle after `bus_re_i`.
- R2: Control bit 3 is the host request and bit 4 is the grant. The grant reads 1 starting one cycle after the request is seen set. It reads 0 starting one cycle after the request is seen clear.
- R3: A command write with go (bit 0) set is accepted only when grant is held and no access is busy. An ignored command leaves the command register and the switch registers unchanged.
- R4: After acceptance, the go bit reads 1 for exactly 4 clock edges, counting the accepting edge. After that it reads 0 and the access has completed.
- R5: For a write command (bit 1 = 1), the 64-bit value {write-data high, write-data low} is stored at the addressed page (bits 31:24) and register (bits 23:16).
- R6: A read command (bit 1 = 0) loads read-data high and low with bits 63:32 and 31:0 of the addressed register at completion. Read data then holds through later write commands.
- R7: Writes to the write-data registers are ignored while an access is busy.
- R8: A command write with bit 2 set ends any busy access at once and performs no access. It clears both write-data and both read-data registers, and its go bit is ignored.
- R9: The interrupt register latches a 1 on any cycle its pulse input bit is high and holds it. Writing 1 to a bit clears it and writing 0 has no effect. A pulse in the same cycle as its clear wins, and writing all ones clears everything.
- R10: `irq_o` is high exactly when control bit 1 (interrupt enable) is set and at least one interrupt bit is pending.
- R11: The control register reads back the enable bit (1) and request bit (3) as written, and bit 6 mirrors `init_done_i`.
- R12: The command register reads back page, register offset and direction of the last accepted command, with bit 2 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the bus access |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Registered bus read data |
| irq_pulse_i | input | NUM_IRQ | Interrupt pulses from the switch |
| init_done_i | input | 1 | Switch initialisation complete |
| irq_o | output | 1 | Gated host interrupt |

## Verification
The assertions assume that the host never drives `bus_we_i` and `bus_re_i` in the same cycle. They also assume that interrupt pulse inputs are at known levels from reset onward. The bench drives every bus access through tasks that raise one strobe for exactly one cycle, and it keeps the pulse inputs at zero except in single-cycle bursts. Checks of busy timing, ignored commands and stage locking depend on these fixed one-cycle accesses, so the bench counts every accept edge by construction and does not poll.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  localparam int BUS_DW = 32;

  localparam logic [7:0] OFF_CMD   = 8'h2C;
  localparam logic [7:0] OFF_WD_HI = 8'h30;
  localparam logic [7:0] OFF_WD_LO = 8'h34;
  localparam logic [7:0] OFF_RD_HI = 8'h38;
  localparam logic [7:0] OFF_RD_LO = 8'h3C;
  localparam logic [7:0] OFF_CTRL  = 8'h40;
  localparam logic [7:0] OFF_IRQ   = 8'h44;

  localparam int CMD_GO   = 0;
  localparam int CMD_WR   = 1;
  localparam int CMD_CLR  = 2;
  localparam int CMD_REG  = 16;
  localparam int CMD_PAGE = 24;

  localparam int CTL_IEN  = 1;
  localparam int CTL_REQ  = 3;
  localparam int CTL_GNT  = 4;
  localparam int CTL_INIT = 6;

  typedef struct packed {
    logic [7:0] page;
    logic [7:0] regno;
    logic       wr;
  } cmd_t;
endpackage

// File: rtl/pgb_regfile.sv
module pgb_regfile #(
  parameter int AW = 5,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (valid_i && we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/pgb_irq_capture.sv
module pgb_irq_capture #(
  parameter int N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pulse_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_eff) | pulse_i;
  end

  assign pend_o = pend_q;

  AST_IRQ_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pulse_i)) == $past(pulse_i))); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q) & ~$past(clr_we_i ? clr_mask_i : '0))
              == ($past(pend_q) & ~$past(clr_we_i ? clr_mask_i : '0)))); // R9
endmodule

// File: rtl/pgb_cmd_engine.sv
module pgb_cmd_engine
  import pgb_pkg::*;
#(
  parameter int LAT    = 4,
  parameter int PAGE_W = 2,
  parameter int REG_W  = 3,
  localparam int AW    = PAGE_W + REG_W,
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          cmd_we_i,
  input  cmd_t          cmd_i,
  input  logic          go_i,
  input  logic          clr_i,
  input  logic          wd_hi_we_i,
  input  logic          wd_lo_we_i,
  input  logic [31:0]   wdata_i,
  output logic          gnt_o,
  output logic          busy_o,
  output cmd_t          cmd_o,
  output logic [63:0]   wd_o,
  output logic [63:0]   rd_o,
  output logic          sw_valid_o,
  output logic          sw_we_o,
  output logic [AW-1:0] sw_addr_o,
  output logic [63:0]   sw_wdata_o,
  input  logic [63:0]   sw_rdata_i
);
  logic             gnt_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  cmd_t             cmd_q;
  logic [31:0]      wd_hi_q, wd_lo_q;
  logic [63:0]      rd_q;
  logic             clr_hit, accept, last;

  assign clr_hit = cmd_we_i && clr_i;
  assign accept  = cmd_we_i && go_i && !clr_i && gnt_q && !busy_q;
  assign last    = busy_q && (cnt_q == CNT_W'(LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= 1'b0;
    else         gnt_q <= req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
    end else if (clr_hit) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      cmd_q  <= cmd_i;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // staging locked while busy so the access sees stable data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_hi_q <= '0;
      wd_lo_q <= '0;
    end else if (clr_hit) begin
      wd_hi_q <= '0;
      wd_lo_q <= '0;
    end else if (!busy_q) begin
      if (wd_hi_we_i) wd_hi_q <= wdata_i;
      if (wd_lo_we_i) wd_lo_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_q <= '0;
    else if (clr_hit)           rd_q <= '0;
    else if (last && !cmd_q.wr) rd_q <= sw_rdata_i;
  end

  assign gnt_o      = gnt_q;
  assign busy_o     = busy_q;
  assign cmd_o      = cmd_q;
  assign wd_o       = {wd_hi_q, wd_lo_q};
  assign rd_o       = rd_q;
  assign sw_valid_o = last && !clr_hit;
  assign sw_we_o    = cmd_q.wr;
  assign sw_addr_o  = {cmd_q.page[PAGE_W-1:0], cmd_q.regno[REG_W-1:0]};
  assign sw_wdata_o = {wd_hi_q, wd_lo_q};

  AST_GNT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !gnt_o); // R2

  AST_ACCEPT_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ($past(gnt_q) && $past(cmd_we_i))); // R3

  AST_BUSY_ENDS_WITH_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(sw_valid_o) || $past(clr_hit))); // R4

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_valid_o && !sw_we_o) && !clr_hit |=> $stable(rd_o)); // R6

  AST_STAGE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !clr_hit |=> $stable(wd_o)); // R7

  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> (!busy_o && wd_o == '0 && rd_o == '0)); // R8
endmodule

// File: rtl/pgb_bridge.sv
module pgb_bridge
  import pgb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 2,
  parameter int REG_W   = 3,
  parameter int LAT     = 4,
  parameter int NUM_IRQ = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic               bus_re_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_pulse_i,
  input  logic               init_done_i,
  output logic               irq_o
);
  localparam int AW = PAGE_W + REG_W;

  logic hit_cmd, hit_wdh, hit_wdl, hit_rdh, hit_rdl, hit_ctl, hit_irq;
  assign hit_cmd = bus_addr_i == ADDR_W'(OFF_CMD);
  assign hit_wdh = bus_addr_i == ADDR_W'(OFF_WD_HI);
  assign hit_wdl = bus_addr_i == ADDR_W'(OFF_WD_LO);
  assign hit_rdh = bus_addr_i == ADDR_W'(OFF_RD_HI);
  assign hit_rdl = bus_addr_i == ADDR_W'(OFF_RD_LO);
  assign hit_ctl = bus_addr_i == ADDR_W'(OFF_CTRL);
  assign hit_irq = bus_addr_i == ADDR_W'(OFF_IRQ);

  logic req_q, ien_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (bus_we_i && hit_ctl) begin
      req_q <= bus_wdata_i[CTL_REQ];
      ien_q <= bus_wdata_i[CTL_IEN];
    end
  end

  cmd_t cmd_in, cmd_cur;
  assign cmd_in.page  = bus_wdata_i[CMD_PAGE +: 8];
  assign cmd_in.regno = bus_wdata_i[CMD_REG +: 8];
  assign cmd_in.wr    = bus_wdata_i[CMD_WR];

  logic          gnt, busy, sw_valid, sw_we;
  logic [63:0]   wd, rd, sw_wdata, sw_rdata;
  logic [AW-1:0] sw_addr;

  pgb_cmd_engine #(
    .LAT    (LAT),
    .PAGE_W (PAGE_W),
    .REG_W  (REG_W)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_q),
    .cmd_we_i   (bus_we_i && hit_cmd),
    .cmd_i      (cmd_in),
    .go_i       (bus_wdata_i[CMD_GO]),
    .clr_i      (bus_wdata_i[CMD_CLR]),
    .wd_hi_we_i (bus_we_i && hit_wdh),
    .wd_lo_we_i (bus_we_i && hit_wdl),
    .wdata_i    (bus_wdata_i),
    .gnt_o      (gnt),
    .busy_o     (busy),
    .cmd_o      (cmd_cur),
    .wd_o       (wd),
    .rd_o       (rd),
    .sw_valid_o (sw_valid),
    .sw_we_o    (sw_we),
    .sw_addr_o  (sw_addr),
    .sw_wdata_o (sw_wdata),
    .sw_rdata_i (sw_rdata)
  );

  pgb_regfile #(
    .AW (AW),
    .DW (64)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sw_valid),
    .we_i    (sw_we),
    .addr_i  (sw_addr),
    .wdata_i (sw_wdata),
    .rdata_o (sw_rdata)
  );

  logic [NUM_IRQ-1:0] pend;

  pgb_irq_capture #(
    .N (NUM_IRQ)
  ) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (irq_pulse_i),
    .clr_we_i   (bus_we_i && hit_irq),
    .clr_mask_i (bus_wdata_i[NUM_IRQ-1:0]),
    .pend_o     (pend)
  );

  logic [31:0] cmd_rb, ctl_rb, rd_mux, rdata_q;
  assign cmd_rb = {cmd_cur.page, cmd_cur.regno, 14'd0, cmd_cur.wr, busy};

  always_comb begin
    ctl_rb           = '0;
    ctl_rb[CTL_IEN]  = ien_q;
    ctl_rb[CTL_REQ]  = req_q;
    ctl_rb[CTL_GNT]  = gnt;
    ctl_rb[CTL_INIT] = init_done_i;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cmd) rd_mux = cmd_rb;
    if (hit_wdh) rd_mux = wd[63:32];
    if (hit_wdl) rd_mux = wd[31:0];
    if (hit_rdh) rd_mux = rd[63:32];
    if (hit_rdl) rd_mux = rd[31:0];
    if (hit_ctl) rd_mux = ctl_rb;
    if (hit_irq) rd_mux = 32'(pend);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_re_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = ien_q && (|pend);

  AST_NO_WR_RD_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_re_i)); // R1

  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> $stable(bus_rdata_o)); // R1

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (ien_q && pend != '0)); // R10
endmodule

// File: tb/pgb_bridge_bench.sv
module pgb_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [12:0] pulse = '0;
  logic        init_done = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pgb_bridge u_pgb_bridge (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_re_i    (re),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_pulse_i (pulse),
    .init_done_i (init_done),
    .irq_o       (irq)
  );

  // scoreboard
  logic [31:0] exp_q  [$];
  logic [31:0] mask_q [$];
  string       tag_q  [$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= re;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = exp_q.pop_front();
      m = mask_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ((rdata & m) !== (e & m)) begin
        fails++;
        $display("FAIL %s: got %08h expected %08h (mask %08h)", t, rdata, e, m);
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; re = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_chk(input logic [7:0] a, input logic [31:0] e,
                         input logic [31:0] m, input string t);
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
    re = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic port_chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and decode
    bus_chk(8'h2C, 32'h0, 32'hFFFF_FFFF, "R1 cmd reset");
    bus_chk(8'h40, 32'h0, 32'hFFFF_FFFF, "R1 ctrl reset");
    bus_chk(8'h44, 32'h0, 32'hFFFF_FFFF, "R1 irq reset");
    bus_chk(8'h3C, 32'h0, 32'hFFFF_FFFF, "R1 rd lo reset");
    bus_chk(8'h00, 32'h0, 32'hFFFF_FFFF, "R1 unmapped 0x00");
    bus_wr(8'h34, 32'h1234_5678);
    bus_wr(8'h30, 32'hA5A5_0001);
    bus_chk(8'h48, 32'h0, 32'hFFFF_FFFF, "R1 unmapped 0x48");
    bus_chk(8'h30, 32'hA5A5_0001, 32'hFFFF_FFFF, "R1 wd hi readback");

    // R3 command without grant is ignored
    bus_wr(8'h2C, 32'h0205_0003);
    bus_chk(8'h2C, 32'h0, 32'hFFFF_FFFF, "R3 no grant");

    // R2 grant one cycle after request
    bus_wr(8'h40, 32'h08);
    bus_chk(8'h40, 32'h08, 32'hFFFF_FFFF, "R2 grant not yet");
    bus_chk(8'h40, 32'h18, 32'hFFFF_FFFF, "R2 grant set");

    // R4 busy window, R12 readback, R5 write
    bus_wr(8'h2C, 32'h0205_0003);
    bus_chk(8'h2C, 32'h1, 32'h1, "R4 busy e1");
    bus_chk(8'h2C, 32'h1, 32'h1, "R4 busy e2");
    bus_chk(8'h2C, 32'h1, 32'h1, "R4 busy e3");
    bus_chk(8'h2C, 32'h1, 32'h1, "R4 busy e4");
    bus_chk(8'h2C, 32'h0205_0002, 32'hFFFF_FFFF, "R4 R12 done readback");

    // R6 read of the written register
    bus_wr(8'h2C, 32'h0205_0001);
    idle(6);
    bus_chk(8'h38, 32'hA5A5_0001, 32'hFFFF_FFFF, "R5 R6 rd hi");
    bus_chk(8'h3C, 32'h1234_5678, 32'hFFFF_FFFF, "R5 R6 rd lo");

    // R7 staging lock, R3 command while busy
    bus_wr(8'h34, 32'hC0DE_0003);
    bus_wr(8'h30, 32'h0);
    bus_wr(8'h2C, 32'h0103_0003);
    bus_wr(8'h34, 32'hFFFF_FFFF);
    bus_wr(8'h2C, 32'h0205_0001);
    idle(6);
    bus_chk(8'h2C, 32'h0103_0002, 32'hFFFF_FFFF, "R3 busy ignore");
    bus_chk(8'h34, 32'hC0DE_0003, 32'hFFFF_FFFF, "R7 stage locked");
    bus_chk(8'h3C, 32'h1234_5678, 32'hFFFF_FFFF, "R6 hold across write");
    bus_wr(8'h2C, 32'h0103_0001);
    idle(6);
    bus_chk(8'h3C, 32'hC0DE_0003, 32'hFFFF_FFFF, "R5 second reg lo");
    bus_chk(8'h38, 32'h0, 32'hFFFF_FFFF, "R5 second reg hi");

    // R8 clear bit aborts
    bus_wr(8'h30, 32'h1111_1111);
    bus_wr(8'h34, 32'h2222_2222);
    bus_wr(8'h2C, 32'h0301_0003);
    bus_wr(8'h2C, 32'h0000_0005);
    bus_chk(8'h2C, 32'h0, 32'h1, "R8 busy cleared");
    bus_chk(8'h30, 32'h0, 32'hFFFF_FFFF, "R8 wd hi cleared");
    bus_chk(8'h34, 32'h0, 32'hFFFF_FFFF, "R8 wd lo cleared");
    bus_chk(8'h3C, 32'h0, 32'hFFFF_FFFF, "R8 rd lo cleared");
    bus_wr(8'h2C, 32'h0301_0001);
    idle(6);
    bus_chk(8'h3C, 32'h0, 32'hFFFF_FFFF, "R8 no access lo");
    bus_chk(8'h38, 32'h0, 32'hFFFF_FFFF, "R8 no access hi");

    // R9 R10 interrupt capture
    pulse = 13'h208;
    @(negedge clk);
    pulse = '0;
    bus_chk(8'h44, 32'h208, 32'hFFFF_FFFF, "R9 latched");
    port_chk(irq, 1'b0, "R10 masked");
    bus_wr(8'h40, 32'h0A);
    port_chk(irq, 1'b1, "R10 enabled");
    bus_chk(8'h40, 32'h1A, 32'hFFFF_FFFF, "R11 ctrl readback");
    bus_wr(8'h44, 32'h0000_0008);
    bus_chk(8'h44, 32'h200, 32'hFFFF_FFFF, "R9 w1c one bit");
    pulse = 13'h020;
    bus_wr(8'h44, 32'h0000_0020);
    pulse = '0;
    bus_chk(8'h44, 32'h220, 32'hFFFF_FFFF, "R9 set wins");
    bus_wr(8'h44, 32'hFFFF_FFFF);
    bus_chk(8'h44, 32'h0, 32'hFFFF_FFFF, "R9 clear all");
    port_chk(irq, 1'b0, "R10 none pending");
    init_done = 1'b1;
    bus_chk(8'h40, 32'h5A, 32'hFFFF_FFFF, "R11 init done");
    init_done = 1'b0;

    // R2 release, R3 ignored after release
    bus_wr(8'h40, 32'h02);
    bus_chk(8'h40, 32'h12, 32'hFFFF_FFFF, "R2 grant lingers");
    bus_chk(8'h40, 32'h02, 32'hFFFF_FFFF, "R2 grant dropped");
    bus_wr(8'h2C, 32'h0205_0001);
    bus_chk(8'h2C, 32'h0301_0000, 32'hFFFF_FFFF, "R3 released ignore");

    idle(3);
    finish_run();
  end
endmodule